// File: doc/BRIEF.md
# Dual-Issue Pairing and Stall Control

This block is the in-order issue stage of a two-wide pipeline. Every cycle the decoder presents two instructions (slot 0 is older than slot 1), each tagged with a class, a sub-operation, a destination and two source registers. The block decides whether both issue, only the older one issues, or neither issues. Its decision rests on three things: a fixed table of class pairs that the register file ports can serve together, a countdown scoreboard that tracks when each pending result becomes readable, and busy timers for the multiplier and the divider, which are not pipelined.

When any instruction of the presented pair is left unissued, the block raises a stall. The front end then holds the same pair on the inputs. If slot 0 has already gone out, a leftover flag is set so that slot 0 is not issued a second time, and slot 1 issues alone once it is ready. Execution units and register data are outside this block.

Register identifiers are 6 bits wide. Bit 5 selects the file (0 = integer, 1 = floating-point) and bits 4:0 select the register within that file.

Top module: `dual_issue_ctrl`

## Requirements
- R1: After reset no slot issues and stall is low while both valids are low. Every scoreboard entry and both unit timers are clear, so an instruction presented right after reset issues in that same cycle.
- R2: The following unordered class pairs issue together in one cycle when both instructions are ready and independent: integer operate (class 0) with FP operate (class 1), integer operate with integer branch (class 6), FP operate with FP branch (class 7), and any memory class (2 = int load, 3 = int store, 4 = FP load, 5 = FP store) with either operate class.
- R3: No other pair issues together. Integer operate with FP store, and FP operate with integer store, are never paired. For such a pair, slot 0 issues alone with stall high, and slot 1 issues on a later cycle as soon as it is ready.
- R4: Slot 1 never issues while a valid slot 0 of the same pair is still unissued.
- R5: Stall is high in exactly the cycles where a valid instruction of the presented pair ends the cycle unissued. Stall is low when both slots are invalid.
- R6: A source that reads a pending destination waits until L cycles after its producer issued. L is 1 for a simple integer operation (sub 0 or 3), 2 for a shift or byte operation (integer sub 1), and 3 for a load.
- R7: Slot 1 is not paired with slot 0 when it reads slot 0's destination or writes the same destination.
- R8: An instruction whose destination still has a pending write waits until that write's countdown reaches zero.
- R9: An integer multiply (integer sub 2) has latency 19 + min(extra, 4). The multiplier stays busy for that many cycles, and another multiply waits until the busy period has ended.
- R10: FP operate latency is 6 for sub 0 or 3. FP sub 1 is a single divide with latency 31, and FP sub 2 is a double divide with latency 61. The divider stays busy for the full divide latency, and a second divide waits until it is free.
- R11: Register 31 of each file (identifiers 31 and 63) reads as always ready and is never marked pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_cls | input | 3 | Slot 0 class code |
| s0_sub | input | 2 | Slot 0 sub-operation |
| s0_extra | input | 3 | Slot 0 extra multiply cycles (clamped to 4) |
| s0_dst | input | 6 | Slot 0 destination register |
| s0_srca | input | 6 | Slot 0 first source |
| s0_srcb | input | 6 | Slot 0 second source |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_cls | input | 3 | Slot 1 class code |
| s1_sub | input | 2 | Slot 1 sub-operation |
| s1_extra | input | 3 | Slot 1 extra multiply cycles |
| s1_dst | input | 6 | Slot 1 destination register |
| s1_srca | input | 6 | Slot 1 first source |
| s1_srcb | input | 6 | Slot 1 second source |
| s0_issue | output | 1 | Slot 0 issues this cycle |
| s1_issue | output | 1 | Slot 1 issues this cycle |
| stall | output | 1 | Hold the front stages and the presented pair |

## Verification
The bound checker watches every cycle for properties that never vary. It checks that the two forbidden store pairings never issue together, that slot 1 never overtakes a pending slot 0, that a leftover slot 1 always raises the stall, and that a busy multiplier or divider never accepts a second operation of its kind. Exact issue distances can only be shown by the bench's scenarios. These include the 2-, 3-, 6-, 20-, 23-, 31- and 61-cycle gaps, the clamping of the multiply extra field, the release of a held slot 1, and the treatment of the zero registers. A random phase compares every cycle against a bench model built from the requirements.

// File: rtl/issue_pkg.sv
`timescale 1ns/1ps
package issue_pkg;

  typedef enum logic [2:0] {
    C_IOP = 3'd0,
    C_FOP = 3'd1,
    C_ILD = 3'd2,
    C_IST = 3'd3,
    C_FLD = 3'd4,
    C_FST = 3'd5,
    C_IBR = 3'd6,
    C_FBR = 3'd7
  } iclass_e;

  function automatic logic cls_is_op(iclass_e c);
    return (c == C_IOP) || (c == C_FOP);
  endfunction

  function automatic logic cls_is_mem(iclass_e c);
    return (c == C_ILD) || (c == C_IST) || (c == C_FLD) || (c == C_FST);
  endfunction

  function automatic logic cls_has_dst(iclass_e c);
    return (c == C_IOP) || (c == C_FOP) || (c == C_ILD) || (c == C_FLD);
  endfunction

  // one ordering of an allowed pair; port limits of the register files
  function automatic logic pair_one_way(iclass_e x, iclass_e y);
    logic mem_op;
    mem_op = cls_is_mem(x) && cls_is_op(y) &&
             !(y == C_IOP && x == C_FST) && !(y == C_FOP && x == C_IST);
    return (x == C_IOP && y == C_FOP) || (x == C_IOP && y == C_IBR) ||
           (x == C_FOP && y == C_FBR) || mem_op;
  endfunction

  function automatic logic pair_allowed(iclass_e a, iclass_e b);
    return pair_one_way(a, b) || pair_one_way(b, a);
  endfunction

endpackage

// File: rtl/issue_lat_calc.sv
`timescale 1ns/1ps
module issue_lat_calc
  import issue_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int EXTRA_W   = 3,
  parameter int ALU_LAT   = 1,
  parameter int SHIFT_LAT = 2,
  parameter int LOAD_LAT  = 3,
  parameter int MUL_BASE  = 19,
  parameter int MUL_SPAN  = 4,
  parameter int FP_LAT    = 6,
  parameter int DIVS_LAT  = 31,
  parameter int DIVD_LAT  = 61
) (
  input  iclass_e              cls,
  input  logic [1:0]           sub,
  input  logic [EXTRA_W-1:0]   extra,
  output logic [CNT_W-1:0]     lat_m1,
  output logic                 is_mul,
  output logic                 is_div,
  output logic                 has_dst
);

  int lat;
  int ext_i;

  always_comb begin
    ext_i = int'(extra);
    if (ext_i > MUL_SPAN) ext_i = MUL_SPAN;
    is_mul = 1'b0;
    is_div = 1'b0;
    unique case (cls)
      C_IOP: begin
        if (sub == 2'd1)      lat = SHIFT_LAT;
        else if (sub == 2'd2) begin
          lat    = MUL_BASE + ext_i;
          is_mul = 1'b1;
        end
        else                  lat = ALU_LAT;
      end
      C_FOP: begin
        if (sub == 2'd1) begin
          lat    = DIVS_LAT;
          is_div = 1'b1;
        end else if (sub == 2'd2) begin
          lat    = DIVD_LAT;
          is_div = 1'b1;
        end else lat = FP_LAT;
      end
      C_ILD, C_FLD: lat = LOAD_LAT;
      default:      lat = 1;
    endcase
    lat_m1  = CNT_W'(lat - 1);
    has_dst = cls_has_dst(cls);
  end

endmodule

// File: rtl/issue_scoreboard.sv
`timescale 1ns/1ps
module issue_scoreboard #(
  parameter int NREG  = 32,
  parameter int REG_W = 6,
  parameter int CNT_W = 6,
  parameter int NSLOT = 2,
  parameter int NQ    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en  [NSLOT],
  input  logic [REG_W-1:0] wr_idx [NSLOT],
  input  logic [CNT_W-1:0] wr_cnt [NSLOT],
  input  logic [REG_W-1:0] rd_idx [NQ],
  output logic             rd_free[NQ]
);

  localparam int NENT = 2 * NREG;

  logic [CNT_W-1:0] cnt_q [NENT];
  logic [CNT_W-1:0] cnt_d [NENT];

  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      cnt_d[e] = (cnt_q[e] != '0) ? cnt_q[e] - 1'b1 : '0;
      for (int s = NSLOT - 1; s >= 0; s--) begin
        if (wr_en[s] && wr_idx[s] == REG_W'(e)) cnt_d[e] = wr_cnt[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NENT; e++) cnt_q[e] <= '0;
    end else begin
      for (int e = 0; e < NENT; e++) cnt_q[e] <= cnt_d[e];
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_rd
    logic zero_reg;
    assign zero_reg   = (rd_idx[q][REG_W-2:0] == {(REG_W-1){1'b1}});
    assign rd_free[q] = zero_reg || (cnt_q[rd_idx[q]] == '0);
  end

endmodule

// File: rtl/issue_busy_timer.sv
`timescale 1ns/1ps
module issue_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= load;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/issue_pair_check.sv
`timescale 1ns/1ps
module issue_pair_check
  import issue_pkg::*;
#(
  parameter int REG_W = 6
) (
  input  iclass_e          cls0,
  input  iclass_e          cls1,
  input  logic             has_dst0,
  input  logic             has_dst1,
  input  logic [REG_W-1:0] dst0,
  input  logic [REG_W-1:0] dst1,
  input  logic [REG_W-1:0] srca1,
  input  logic [REG_W-1:0] srcb1,
  output logic             can_pair
);

  logic dst0_real;
  logic dep;

  assign dst0_real = has_dst0 && (dst0[REG_W-2:0] != {(REG_W-1){1'b1}});
  assign dep = dst0_real &&
               ((srca1 == dst0) || (srcb1 == dst0) || (has_dst1 && dst1 == dst0));
  assign can_pair = pair_allowed(cls0, cls1) && !dep;

endmodule

// File: rtl/dual_issue_ctrl.sv
`timescale 1ns/1ps
module dual_issue_ctrl
  import issue_pkg::*;
#(
  parameter int NREG      = 32,
  parameter int REG_W     = $clog2(NREG) + 1,
  parameter int EXTRA_W   = 3,
  parameter int ALU_LAT   = 1,
  parameter int SHIFT_LAT = 2,
  parameter int LOAD_LAT  = 3,
  parameter int MUL_BASE  = 19,
  parameter int MUL_SPAN  = 4,
  parameter int FP_LAT    = 6,
  parameter int DIVS_LAT  = 31,
  parameter int DIVD_LAT  = 61
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s0_valid,
  input  logic [2:0]         s0_cls,
  input  logic [1:0]         s0_sub,
  input  logic [EXTRA_W-1:0] s0_extra,
  input  logic [REG_W-1:0]   s0_dst,
  input  logic [REG_W-1:0]   s0_srca,
  input  logic [REG_W-1:0]   s0_srcb,
  input  logic               s1_valid,
  input  logic [2:0]         s1_cls,
  input  logic [1:0]         s1_sub,
  input  logic [EXTRA_W-1:0] s1_extra,
  input  logic [REG_W-1:0]   s1_dst,
  input  logic [REG_W-1:0]   s1_srca,
  input  logic [REG_W-1:0]   s1_srcb,
  output logic               s0_issue,
  output logic               s1_issue,
  output logic               stall
);

  localparam int NSLOT   = 2;
  localparam int NRD     = 3;
  localparam int NQ      = NSLOT * NRD;
  localparam int MUL_MAX = MUL_BASE + MUL_SPAN;
  localparam int MAX_A   = (MUL_MAX > DIVD_LAT) ? MUL_MAX : DIVD_LAT;
  localparam int MAX_B   = (DIVS_LAT > FP_LAT) ? DIVS_LAT : FP_LAT;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic               v      [NSLOT];
  iclass_e            cls    [NSLOT];
  logic [1:0]         sub    [NSLOT];
  logic [EXTRA_W-1:0] extra  [NSLOT];
  logic [REG_W-1:0]   dst    [NSLOT];
  logic [REG_W-1:0]   sa     [NSLOT];
  logic [REG_W-1:0]   sb     [NSLOT];

  logic [CNT_W-1:0]   lat_m1 [NSLOT];
  logic               is_mul [NSLOT];
  logic               is_div [NSLOT];
  logic               hasd   [NSLOT];
  logic               rdy    [NSLOT];
  logic               iss    [NSLOT];

  logic [REG_W-1:0]   rd_idx  [NQ];
  logic               rd_free [NQ];
  logic               wr_en   [NSLOT];

  logic lead_q;
  logic mul_busy, div_busy;
  logic can_pair, slot0_clear;
  logic mul_start, div_start;
  logic [CNT_W-1:0] mul_load, div_load;

  always_comb begin
    v[0] = s0_valid;            v[1] = s1_valid;
    cls[0] = iclass_e'(s0_cls); cls[1] = iclass_e'(s1_cls);
    sub[0] = s0_sub;            sub[1] = s1_sub;
    extra[0] = s0_extra;        extra[1] = s1_extra;
    dst[0] = s0_dst;            dst[1] = s1_dst;
    sa[0] = s0_srca;            sa[1] = s1_srca;
    sb[0] = s0_srcb;            sb[1] = s1_srcb;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic dst_zero;

    issue_lat_calc #(
      .CNT_W(CNT_W), .EXTRA_W(EXTRA_W), .ALU_LAT(ALU_LAT),
      .SHIFT_LAT(SHIFT_LAT), .LOAD_LAT(LOAD_LAT), .MUL_BASE(MUL_BASE),
      .MUL_SPAN(MUL_SPAN), .FP_LAT(FP_LAT), .DIVS_LAT(DIVS_LAT),
      .DIVD_LAT(DIVD_LAT)
    ) i_lat (
      .cls(cls[i]), .sub(sub[i]), .extra(extra[i]),
      .lat_m1(lat_m1[i]), .is_mul(is_mul[i]), .is_div(is_div[i]),
      .has_dst(hasd[i])
    );

    assign dst_zero = (dst[i][REG_W-2:0] == {(REG_W-1){1'b1}});

    always_comb begin
      rd_idx[i*NRD + 0] = sa[i];
      rd_idx[i*NRD + 1] = sb[i];
      rd_idx[i*NRD + 2] = dst[i];
    end

    assign rdy[i] = rd_free[i*NRD + 0] && rd_free[i*NRD + 1] &&
                    (!hasd[i] || rd_free[i*NRD + 2]) &&
                    !(is_mul[i] && mul_busy) && !(is_div[i] && div_busy);

    assign wr_en[i] = iss[i] && hasd[i] && !dst_zero;
  end

  issue_scoreboard #(
    .NREG(NREG), .REG_W(REG_W), .CNT_W(CNT_W), .NSLOT(NSLOT), .NQ(NQ)
  ) i_sb (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(dst), .wr_cnt(lat_m1),
    .rd_idx(rd_idx), .rd_free(rd_free)
  );

  issue_pair_check #(.REG_W(REG_W)) i_pair (
    .cls0(cls[0]), .cls1(cls[1]), .has_dst0(hasd[0]), .has_dst1(hasd[1]),
    .dst0(dst[0]), .dst1(dst[1]), .srca1(sa[1]), .srcb1(sb[1]),
    .can_pair(can_pair)
  );

  // issue decision: slot 0 first, slot 1 only behind it
  assign slot0_clear = lead_q || !v[0];
  assign iss[0] = v[0] && !lead_q && rdy[0];
  assign iss[1] = v[1] && rdy[1] && (slot0_clear || (iss[0] && can_pair));

  assign s0_issue = iss[0];
  assign s1_issue = iss[1];
  assign stall    = (v[0] && !lead_q && !iss[0]) || (v[1] && !iss[1]);

  always_ff @(posedge clk) begin
    if (rst)        lead_q <= 1'b0;
    else if (stall) lead_q <= lead_q | iss[0];
    else            lead_q <= 1'b0;
  end

  assign mul_start = (iss[0] && is_mul[0]) || (iss[1] && is_mul[1]);
  assign mul_load  = (iss[0] && is_mul[0]) ? lat_m1[0] : lat_m1[1];
  assign div_start = (iss[0] && is_div[0]) || (iss[1] && is_div[1]);
  assign div_load  = (iss[0] && is_div[0]) ? lat_m1[0] : lat_m1[1];

  issue_busy_timer #(.CNT_W(CNT_W)) i_mul_busy (
    .clk(clk), .rst(rst), .start(mul_start), .load(mul_load), .busy(mul_busy)
  );

  issue_busy_timer #(.CNT_W(CNT_W)) i_div_busy (
    .clk(clk), .rst(rst), .start(div_start), .load(div_load), .busy(div_busy)
  );

endmodule

// File: rtl/issue_checker.sv
`timescale 1ns/1ps
module issue_checker
  import issue_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       s0_valid,
  input logic [2:0] s0_cls,
  input logic [1:0] s0_sub,
  input logic       s1_valid,
  input logic [2:0] s1_cls,
  input logic [1:0] s1_sub,
  input logic       s0_issue,
  input logic       s1_issue,
  input logic       stall,
  input logic       lead_q,
  input logic       mul_busy,
  input logic       div_busy
);

  logic m0, m1, d0, d1;
  assign m0 = (s0_cls == C_IOP) && (s0_sub == 2'd2);
  assign m1 = (s1_cls == C_IOP) && (s1_sub == 2'd2);
  assign d0 = (s0_cls == C_FOP) && (s0_sub == 2'd1 || s0_sub == 2'd2);
  assign d1 = (s1_cls == C_FOP) && (s1_sub == 2'd1 || s1_sub == 2'd2);

  assert_forbid_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (s0_issue && s1_issue) |->
      !((s0_cls == C_IOP && s1_cls == C_FST) || (s0_cls == C_FST && s1_cls == C_IOP) ||
        (s0_cls == C_FOP && s1_cls == C_IST) || (s0_cls == C_IST && s1_cls == C_FOP)));

  assert_in_order_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_issue && s0_valid && !s0_issue) |-> lead_q);

  assert_leftover_stalls_R5: assert property (@(posedge clk) disable iff (rst)
    (s0_issue && s1_valid && !s1_issue) |-> stall);

  assert_idle_no_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (!s0_valid && !s1_valid) |-> !stall);

  assert_mul_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    mul_busy |-> !((s0_issue && m0) || (s1_issue && m1)));

  assert_mul_marks_busy_R9: assert property (@(posedge clk) disable iff (rst)
    ((s0_issue && m0) || (s1_issue && m1)) |=> mul_busy);

  assert_div_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !((s0_issue && d0) || (s1_issue && d1)));

  assert_div_marks_busy_R10: assert property (@(posedge clk) disable iff (rst)
    ((s0_issue && d0) || (s1_issue && d1)) |=> div_busy);

endmodule

bind dual_issue_ctrl issue_checker i_issue_checker (
  .clk(clk), .rst(rst),
  .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_sub(s0_sub),
  .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_sub(s1_sub),
  .s0_issue(s0_issue), .s1_issue(s1_issue), .stall(stall),
  .lead_q(lead_q), .mul_busy(mul_busy), .div_busy(div_busy)
);

// File: tb/test_dual_issue_ctrl.sv
`timescale 1ns/1ps
module test_dual_issue_ctrl;

  localparam logic [2:0] IOP = 3'd0, FOP = 3'd1, ILD = 3'd2, IST = 3'd3,
                         FLD = 3'd4, FST = 3'd5, IBR = 3'd6, FBR = 3'd7;
  localparam logic [5:0] ZI = 6'd31, ZF = 6'd63;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       v [2];
  logic [2:0] c [2];
  logic [1:0] s [2];
  logic [2:0] x [2];
  logic [5:0] d [2];
  logic [5:0] a [2];
  logic [5:0] b [2];
  logic s0_issue, s1_issue, stall;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit a0, a1, ast;

  int sbm [64];
  int mulc = 0, divc = 0;
  bit leadm = 1'b0;

  always #2 clk = ~clk;

  dual_issue_ctrl i_dual_issue_ctrl (
    .clk(clk), .rst(rst),
    .s0_valid(v[0]), .s0_cls(c[0]), .s0_sub(s[0]), .s0_extra(x[0]),
    .s0_dst(d[0]), .s0_srca(a[0]), .s0_srcb(b[0]),
    .s1_valid(v[1]), .s1_cls(c[1]), .s1_sub(s[1]), .s1_extra(x[1]),
    .s1_dst(d[1]), .s1_srca(a[1]), .s1_srcb(b[1]),
    .s0_issue(s0_issue), .s1_issue(s1_issue), .stall(stall)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic int m_lat(logic [2:0] cc, logic [1:0] ss, logic [2:0] xx);
    int e = (int'(xx) > 4) ? 4 : int'(xx);
    if (cc == IOP) return (ss == 1) ? 2 : (ss == 2) ? 19 + e : 1;
    if (cc == FOP) return (ss == 1) ? 31 : (ss == 2) ? 61 : 6;
    if (cc == ILD || cc == FLD) return 3;
    return 1;
  endfunction

  function automatic bit m_hasd(logic [2:0] cc);
    return cc == IOP || cc == FOP || cc == ILD || cc == FLD;
  endfunction

  function automatic bit m_zero(logic [5:0] r);
    return r[4:0] == 5'd31;
  endfunction

  function automatic bit m_free(logic [5:0] r);
    return m_zero(r) || sbm[r] == 0;
  endfunction

  function automatic bit m_mem(logic [2:0] cc);
    return cc >= ILD && cc <= FST;
  endfunction

  function automatic bit m_way(logic [2:0] p, logic [2:0] q);
    return (p == IOP && q == FOP) || (p == IOP && q == IBR) || (p == FOP && q == FBR) ||
           (m_mem(p) && (q == IOP || q == FOP) && !(q == IOP && p == FST) && !(q == FOP && p == IST));
  endfunction

  function automatic bit m_ready(int k);
    bit ismul = (c[k] == IOP && s[k] == 2);
    bit isdiv = (c[k] == FOP && (s[k] == 1 || s[k] == 2));
    return m_free(a[k]) && m_free(b[k]) && (!m_hasd(c[k]) || m_free(d[k])) &&
           !(ismul && mulc > 0) && !(isdiv && divc > 0);
  endfunction

  task automatic m_eval(output bit e0, output bit e1, output bit es);
    bit dep, pairok;
    dep = m_hasd(c[0]) && !m_zero(d[0]) &&
          (a[1] == d[0] || b[1] == d[0] || (m_hasd(c[1]) && d[1] == d[0]));
    pairok = (m_way(c[0], c[1]) || m_way(c[1], c[0])) && !dep;
    e0 = v[0] && !leadm && m_ready(0);
    e1 = v[1] && m_ready(1) && (leadm || !v[0] || (e0 && pairok));
    es = (v[0] && !leadm && !e0) || (v[1] && !e1);
  endtask

  task automatic m_update(bit e0, bit e1, bit es);
    for (int r = 0; r < 64; r++) if (sbm[r] > 0) sbm[r]--;
    if (mulc > 0) mulc--;
    if (divc > 0) divc--;
    for (int k = 0; k < 2; k++) begin
      bit go = (k == 0) ? e0 : e1;
      if (go) begin
        int l = m_lat(c[k], s[k], x[k]);
        if (m_hasd(c[k]) && !m_zero(d[k])) sbm[d[k]] = l - 1;
        if (c[k] == IOP && s[k] == 2) mulc = l - 1;
        if (c[k] == FOP && (s[k] == 1 || s[k] == 2)) divc = l - 1;
      end
    end
    leadm = es ? (leadm | e0) : 1'b0;
  endtask

  // ---------------- check helpers ----------------
  task automatic chk(bit act, bit exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic chk_int(int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after negedge
  task automatic step();
    bit e0, e1, es;
    #1;
    m_eval(e0, e1, es);
    a0 = s0_issue; a1 = s1_issue; ast = stall;
    chk(a0, e0, "R6 model slot0 issue");
    chk(a1, e1, "R4 model slot1 issue");
    chk(ast, es, "R5 model stall");
    @(posedge clk);
    m_update(e0, e1, es);
    @(negedge clk);
  endtask

  task automatic put(int k, bit vv, logic [2:0] cc, logic [1:0] ss, logic [2:0] xx,
                     logic [5:0] dd, logic [5:0] aa, logic [5:0] bb);
    v[k] = vv; c[k] = cc; s[k] = ss; x[k] = xx; d[k] = dd; a[k] = aa; b[k] = bb;
  endtask

  task automatic idle(int n);
    put(0, 0, IOP, 0, 0, ZI, ZI, ZI);
    put(1, 0, IOP, 0, 0, ZI, ZI, ZI);
    repeat (n) step();
  endtask

  // present a producer alone for one cycle, then the consumer in slot 0
  task automatic gap(logic [2:0] pc, logic [1:0] ps, logic [2:0] px, logic [5:0] pd,
                     logic [2:0] cc, logic [1:0] cs, logic [5:0] cd, logic [5:0] ca,
                     int exp, string what);
    int n = 0;
    put(0, 1, pc, ps, px, pd, ZI, ZI);
    put(1, 0, IOP, 0, 0, ZI, ZI, ZI);
    step();
    put(0, 1, cc, cs, 0, cd, ca, ZI);
    do begin
      step();
      n++;
    end while (!a0 && n < 100);
    chk_int(n, exp, what);
    idle(65);
  endtask

  function automatic logic [5:0] rreg();
    logic [4:0] pick [4] = '{5'd0, 5'd1, 5'd2, 5'd31};
    return {1'($urandom % 2), pick[$urandom % 4]};
  endfunction

  function automatic logic [1:0] rsub();
    int r = $urandom % 16;
    return (r < 9) ? 2'd0 : (r < 14) ? 2'd1 : (r == 14) ? 2'd2 : 2'd3;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int n;
    bit saw_early;
    seed = $urandom(32'd20240611);
    for (int r = 0; r < 64; r++) sbm[r] = 0;
    put(0, 0, IOP, 0, 0, ZI, ZI, ZI);
    put(1, 0, IOP, 0, 0, ZI, ZI, ZI);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, then immediate issue of a reader of a general register
    step();
    chk(ast, 1'b0, "R1 stall after reset");
    chk(a0 | a1, 1'b0, "R1 no issue after reset");
    put(0, 1, IOP, 0, 0, 6'd1, 6'd2, 6'd3);
    step();
    chk(a0, 1'b1, "R1 scoreboard clear after reset");
    idle(3);

    // R2: legal pairs
    put(0, 1, IOP, 0, 0, 6'd1, ZI, ZI);
    put(1, 1, FOP, 0, 0, 6'd33, ZF, ZF);
    step();
    chk(a0 & a1, 1'b1, "R2 int op + fp op pair");
    chk(ast, 1'b0, "R2 no stall on legal pair");
    idle(8);
    put(0, 1, FST, 0, 0, ZF, ZF, ZF);
    put(1, 1, FOP, 0, 0, 6'd34, ZF, ZF);
    step();
    chk(a0 & a1, 1'b1, "R2 fp store + fp op pair");
    idle(8);

    // R3: forbidden pair, slot 0 alone then slot 1
    put(0, 1, IOP, 0, 0, 6'd1, ZI, ZI);
    put(1, 1, FST, 0, 0, ZF, ZF, ZF);
    step();
    chk(a0, 1'b1, "R3 int op + fp store: slot0 issues");
    chk(a1, 1'b0, "R3 int op + fp store: slot1 held");
    chk(ast, 1'b1, "R3 stall while slot1 held");
    step();
    chk(a0, 1'b0, "R3 slot0 not reissued");
    chk(a1, 1'b1, "R3 slot1 issues next cycle");
    chk(ast, 1'b0, "R5 stall released");
    idle(3);
    put(0, 1, IST, 0, 0, ZI, ZI, ZI);
    put(1, 1, FOP, 0, 0, 6'd35, ZF, ZF);
    step();
    chk(a1, 1'b0, "R3 int store + fp op not paired");
    idle(8);
    put(0, 1, IOP, 0, 0, 6'd1, ZI, ZI);
    put(1, 1, IOP, 0, 0, 6'd2, ZI, ZI);
    step();
    chk(a1, 1'b0, "R3 two int ops not paired");
    idle(3);

    // R7 + R10: intra-pair RAW, fp latency 6
    put(0, 1, FOP, 0, 0, 6'd33, ZF, ZF);
    put(1, 1, FBR, 0, 0, ZF, 6'd33, ZF);
    step();
    chk(a0 & !a1 & ast, 1'b1, "R7 dependent slot1 not paired");
    n = 0;
    do begin step(); n++; end while (!a1 && n < 100);
    chk_int(n, 6, "R10 fp op result gap");
    idle(10);
    // R7 same destination
    put(0, 1, ILD, 0, 0, 6'd4, ZI, ZI);
    put(1, 1, IOP, 0, 0, 6'd4, ZI, ZI);
    step();
    chk(a1, 1'b0, "R7 same destination not paired");
    idle(6);

    // R6 latencies
    gap(IOP, 0, 0, 6'd1, IOP, 0, ZI, 6'd1, 1, "R6 alu gap");
    gap(IOP, 1, 0, 6'd2, IOP, 0, ZI, 6'd2, 2, "R6 shift gap");
    gap(ILD, 0, 0, 6'd3, IOP, 0, ZI, 6'd3, 3, "R6 load gap");
    // R8 write after write
    gap(IOP, 1, 0, 6'd5, IOP, 0, 6'd5, ZI, 2, "R8 waw gap");
    // R9 multiply latency, clamp and busy unit
    gap(IOP, 2, 7, 6'd6, IOP, 0, ZI, 6'd6, 23, "R9 mul clamp gap");
    gap(IOP, 2, 0, 6'd6, IOP, 0, ZI, 6'd6, 19, "R9 mul base gap");
    gap(IOP, 2, 1, 6'd7, IOP, 2, ZI, ZI, 20, "R9 mul busy gap");
    // R10 divides
    gap(FOP, 2, 0, 6'd40, FOP, 0, ZF, 6'd40, 61, "R10 double divide gap");
    gap(FOP, 1, 0, 6'd41, FOP, 1, ZF, ZF, 31, "R10 divider busy gap");
    // R11 zero registers
    gap(IOP, 2, 4, ZI, IOP, 0, ZI, ZI, 1, "R11 int zero reg never pending");
    gap(FLD, 0, 0, ZF, FOP, 0, 6'd33, ZF, 1, "R11 fp zero reg never pending");

    // R4: blocked slot 0 keeps an independent slot 1 back
    put(0, 1, IOP, 2, 0, 6'd8, ZI, ZI);
    put(1, 0, IOP, 0, 0, ZI, ZI, ZI);
    step();
    put(0, 1, IOP, 0, 0, ZI, 6'd8, ZI);
    put(1, 1, FOP, 0, 0, 6'd36, ZF, ZF);
    n = 0;
    saw_early = 1'b0;
    do begin
      step();
      n++;
      if (a1 && !a0) saw_early = 1'b1;
    end while (!a0 && n < 100);
    chk(saw_early, 1'b0, "R4 slot1 never ahead of slot0");
    chk(a1, 1'b1, "R4 slot1 pairs once slot0 issues");
    chk_int(n, 19, "R4 pair issue cycle");
    idle(65);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if (!ast) begin
        for (int k = 0; k < 2; k++)
          put(k, ($urandom % 8) != 0, 3'($urandom % 8), rsub(), 3'($urandom % 8),
              rreg(), rreg(), rreg());
      end
      step();
    end
    idle(70);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule